// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shift Register

The block holds a parallel word in a storage register and hands it to a shift register. The shift register then sends the word out one bit at a time on a single serial line. The storage register captures the parallel input when its own storage clock rises. A low level on the load control copies the stored word into the shift register, and this copy takes priority over shifting. While the load control is high, each rising edge of the shift clock moves the chain one place towards the output, and the serial input bit enters the first stage. The serial input lets several blocks be chained end to end.

The serial output is the last stage of the shift chain. It is presented as a data line with a separate drive enable, so that several blocks can share one wire. Raising the disable input drops the enable and changes nothing else.

Both external clocks are treated as slow control inputs. They are sampled in the single system clock domain, and rising edges are found by comparing each sample with the one before. The level-sensitive load is sampled on every system clock. Every effect of an input appears one system clock after the edge at which it is sampled.

Top module: `latched_piso`

## Requirements
- R1: The storage register takes `par_d_i` at the system clock edge where `stor_clk_i` is first seen high after being low, and keeps its value at every other edge.
- R2: With `load_ni` high, a detected rising edge of `shift_clk_i` moves every stage up by one position (stage k takes stage k-1) and puts `ser_i` into stage 0.
- R3: With `load_ni` low, the shift register is loaded from the storage register at every system clock, and any shift clock edge in that cycle is ignored.
- R4: When a storage clock edge falls in a cycle where `load_ni` is low, the newly captured word reaches the shift register in that same cycle.
- R5: When the storage and shift clocks rise in the same cycle with `load_ni` high, the shift acts on the old shift contents and the storage register takes the new word, so both happen at one edge.
- R6: Stage k is loaded from bit k of the stored word and `ser_o` is stage WIDTH-1. A loaded word therefore leaves MSB first.
- R7: `ser_en_o` is the inverse of `hiz_i`, and `ser_o` always shows the last stage.
- R8: `hiz_i` changes neither register. A word shifted out after a period with the output disabled is unchanged.
- R9: After reset both registers are zero, and no clock edge is seen until a clock input has been low and then high.
- R10: A clock input held high causes only one action. Later changes of `par_d_i` are not captured until the storage clock has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_d_i | input | WIDTH | Parallel input word |
| ser_i | input | 1 | Serial input into stage 0 |
| stor_clk_i | input | 1 | Storage clock; its rising edge captures the parallel word |
| shift_clk_i | input | 1 | Shift clock; its rising edge shifts the chain |
| load_ni | input | 1 | Active-low load from the storage register into the shift register |
| hiz_i | input | 1 | High level releases the serial output |
| ser_o | output | 1 | Last shift stage |
| ser_en_o | output | 1 | Drive enable for ser_o |

## Verification
A storage edge can fall in the same cycle as a shift edge or as an active load, and in each case two updates land at one system clock edge. The bench raises both external clocks before the same system edge with the load high, and it also raises the storage clock while the load is held low. In the first case it checks that the bit now shown on the output comes from the old shift contents. A later load must then deliver the new word. In the second case it checks that the new word can be shifted out at once. The same collisions also arise in long random runs, where a bench reference model that follows the requirements judges every output cycle by cycle.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  localparam int unsigned PISO_WIDTH = 8;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } chain_op_e;
endpackage

// File: rtl/piso_edge_det.sv
`timescale 1ns/1ps
module piso_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R10
endmodule

// File: rtl/piso_store_reg.sv
`timescale 1ns/1ps
module piso_store_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] q;

  assign nxt_o = cap_i ? d_i : q;
  assign q_o   = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt_o;
  end

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o)); // R1
  AST_STORE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i)); // R1
endmodule

// File: rtl/piso_shift_chain.sv
`timescale 1ns/1ps
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chain_op_e        op_i,
  input  logic [WIDTH-1:0] load_d_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q, stage_d;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic prev_bit;
    if (k == 0) begin : g_head
      assign prev_bit = ser_i;
    end else begin : g_body
      assign prev_bit = stage_q[k-1];
    end
    always_comb begin
      unique case (op_i)
        OP_LOAD:  stage_d[k] = load_d_i[k];
        OP_SHIFT: stage_d[k] = prev_bit;
        default:  stage_d[k] = stage_q[k];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SHIFT |=> stage_o == {$past(stage_o[WIDTH-2:0]), $past(ser_i)}); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(stage_o)); // R2
endmodule

// File: rtl/latched_piso.sv
`timescale 1ns/1ps
module latched_piso
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = PISO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] par_d_i,
  input  logic             ser_i,
  input  logic             stor_clk_i,
  input  logic             shift_clk_i,
  input  logic             load_ni,
  input  logic             hiz_i,
  output logic             ser_o,
  output logic             ser_en_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             stor_rise, shift_rise;
  logic [WIDTH-1:0] store_q, store_nxt, chain_q;
  chain_op_e        op;

  piso_edge_det u_stor_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (stor_clk_i),
    .rise_o (stor_rise)
  );

  piso_edge_det u_shift_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (shift_clk_i),
    .rise_o (shift_rise)
  );

  piso_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (stor_rise),
    .d_i    (par_d_i),
    .q_o    (store_q),
    .nxt_o  (store_nxt)
  );

  // level load wins over a shift edge
  always_comb begin
    if (!load_ni)        op = OP_LOAD;
    else if (shift_rise) op = OP_SHIFT;
    else                 op = OP_HOLD;
  end

  piso_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .load_d_i (store_nxt),
    .ser_i    (ser_i),
    .stage_o  (chain_q)
  );

  assign ser_o    = chain_q[MSB];
  assign ser_en_o = ~hiz_i;

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !stor_rise) |=> chain_q == store_q); // R3
  AST_LOAD_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && stor_rise) |=> chain_q == $past(par_d_i)); // R4
  AST_JOINT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && stor_rise && shift_rise) |=> chain_q[MSB] == $past(chain_q[MSB-1])); // R5
  AST_HIZ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_i && load_ni && !shift_rise && !stor_rise) |=> ($stable(chain_q) && $stable(store_q))); // R8
endmodule

// File: tb/latched_piso_tb.sv
`timescale 1ns/1ps
module latched_piso_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par_d = '0;
  logic         ser = 1'b0, stor_clk = 1'b0, shift_clk = 1'b0, load_n = 1'b1, hiz = 1'b0;
  logic         ser_o, ser_en_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] m_store = '0, m_shift = '0;
  logic         m_sprev = 1'b0, m_hprev = 1'b0;

  always #10 clk = ~clk;

  latched_piso #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .par_d_i(par_d), .ser_i(ser),
    .stor_clk_i(stor_clk), .shift_clk_i(shift_clk), .load_ni(load_n),
    .hiz_i(hiz), .ser_o(ser_o), .ser_en_o(ser_en_o)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] shifted(logic [W-1:0] v, logic b);
    return {v[W-2:0], b};
  endfunction

  // reference update from the requirements, using inputs seen at the edge
  task automatic model_edge();
    logic s_r, h_r;
    logic [W-1:0] s_new;
    s_r   = stor_clk & ~m_sprev;
    h_r   = shift_clk & ~m_hprev;
    s_new = s_r ? par_d : m_store;
    if (!load_n)  m_shift = s_new;
    else if (h_r) m_shift = shifted(m_shift, ser);
    m_store = s_new;
    m_sprev = stor_clk;
    m_hprev = shift_clk;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    chk("R7 model ser_o", {7'd0, ser_o}, {7'd0, m_shift[W-1]});
    chk("R7 model ser_en_o", {7'd0, ser_en_o}, {7'd0, ~hiz});
  endtask

  task automatic pulse_stor(logic [W-1:0] v);
    par_d = v; stor_clk = 1'b1; step();
    stor_clk = 1'b0; step();
  endtask

  task automatic load_pulse();
    load_n = 1'b0; step();
    load_n = 1'b1; step();
  endtask

  task automatic shift_out(logic [W-1:0] sin, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], ser_o};
      ser = sin[W-1-i];
      shift_clk = 1'b1; step();
      shift_clk = 1'b0; step();
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R9 reset ser_o", {7'd0, ser_o}, 8'h00);
    chk("R7 reset enable", {7'd0, ser_en_o}, 8'h01);
    rst_n = 1'b1;
    step();

    // R6/R2: MSB first out, serial pattern in
    pulse_stor(8'hA5); load_pulse();
    shift_out(8'h3C, got);
    chk("R6 msb-first word", got, 8'hA5);
    shift_out(8'h00, got);
    chk("R2 serial in word", got, 8'h3C);

    // R3: load low overrides shift edges
    pulse_stor(8'h80);
    load_n = 1'b0; ser = 1'b0;
    for (int i = 0; i < 4; i++) begin
      shift_clk = 1'b1; step(); shift_clk = 1'b0; step();
      chk("R3 load overrides shift", {7'd0, ser_o}, 8'h01);
    end
    load_n = 1'b1; step();

    // R4: pass-through while load held low
    load_n = 1'b0; step();
    par_d = 8'h3C; stor_clk = 1'b1; step();
    stor_clk = 1'b0; load_n = 1'b1; step();
    shift_out(8'h00, got);
    chk("R4 pass-through", got, 8'h3C);

    // R5: joint storage and shift edges
    pulse_stor(8'hF0); load_pulse();
    par_d = 8'h0F; ser = 1'b1; stor_clk = 1'b1; shift_clk = 1'b1; step();
    chk("R5 shift used old contents", {7'd0, ser_o}, 8'h01);
    stor_clk = 1'b0; shift_clk = 1'b0; step();
    load_pulse();
    shift_out(8'h00, got);
    chk("R5 storage took new word", got, 8'h0F);

    // R8: disable changes no state
    pulse_stor(8'h96); load_pulse();
    hiz = 1'b1;
    repeat (5) step();
    chk("R8 enable dropped", {7'd0, ser_en_o}, 8'h00);
    hiz = 1'b0; step();
    shift_out(8'h00, got);
    chk("R8 word kept", got, 8'h96);

    // R10: held-high storage clock captures once
    par_d = 8'h5A; stor_clk = 1'b1; step();
    par_d = 8'hFF; repeat (3) step();
    stor_clk = 1'b0; step();
    load_pulse();
    shift_out(8'h00, got);
    chk("R10 single capture", got, 8'h5A);

    // R1: storage holds without an edge
    par_d = 8'h11; repeat (3) step();
    load_pulse();
    shift_out(8'h00, got);
    chk("R1 storage held", got, 8'h5A);

    // random mix checked cycle by cycle against the model
    for (int n = 0; n < 4000; n++) begin
      par_d     = W'($urandom);
      ser       = 1'($urandom);
      stor_clk  = ($urandom % 4) == 0 ? ~stor_clk : stor_clk;
      shift_clk = ($urandom % 2) == 0 ? ~shift_clk : shift_clk;
      load_n    = ($urandom % 8) != 0;
      hiz       = ($urandom % 4) == 0;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule